// File: doc/BRIEF.md
# Processor Status Trace Encoder

This block sits beside a CPU core and turns its per-cycle execution events into two 4-bit streams for an external debugger or logic analyzer. The status nibble says what the core did in that cycle: it began an instruction, took a branch, entered user mode, returned from an exception, or executed a pulse or data-write instruction. It also reports when the core sits in one of the long-running modes (exception processing, emulator mode, stopped, halted). The data nibble carries payload bytes: the operand of a data-write instruction, or the target address of a taken branch.

Each payload is announced on the status nibble by a byte-count marker in the cycle just before its first data nibble. Bytes then leave least significant first, as two nibbles each, low nibble first. A second request that arrives while a payload is in flight waits in a single pending slot and starts right after the first one with no gap. A request that finds the slot occupied is discarded, and a sticky overflow flag goes high. Every output is registered: an event sampled at a clock edge shows on the status nibble in the cycle after that edge.

Top module: `pst_trace_enc`

## Requirements
- R1: The event codes on `pst` are: 0x1 instruction begin, 0x3 user-mode entry, 0x4 pulse or data write, 0x5 taken branch, 0x7 return from exception. A cycle with no event shows 0x0. The values 0x2 and 0x6 never appear.
- R2: An instruction that lasts several cycles shows 0x1 in its first cycle and 0x0 in each later cycle in which no other code is due.
- R3: A payload of N bytes (N = 1..4) is announced by the marker 0x7+N, which is 0x8, 0x9, 0xA or 0xB. The marker appears on `pst` in exactly the cycle before the first data nibble.
- R4: Payload bytes leave least significant byte first, each as its low nibble and then its high nibble, so N bytes take 2N consecutive cycles. In any cycle with no payload nibble, `ddata` is 0x0.
- R5: A data write shows 0x4 and then a marker whose size follows `wsize`: 0 gives one byte, 1 gives two bytes, 2 or 3 gives four bytes. The bytes sent are the low bytes of `wdata`. The marker takes the first cycle in which no event or mode code needs the status port. Event codes shown in the meantime delay it.
- R6: A taken branch shows 0x5. With `cfg_br_bytes` = 0 no address is sent. With 1..4, that many low bytes of `br_target` are sent after the matching marker. Values above 4 send four bytes.
- R7: Exception entry (0xC) and emulator entry (0xD) hold until `exc_done`. Stop (0xE) holds until `wake`. Halt (0xF) holds until `restart` and ignores `wake`. While a mode holds, all other event inputs and their payloads are ignored. The exit cycle shows 0x0 unless a marker is due.
- R8: When several events arrive in the same cycle, one is chosen in this order: halt, emulator entry, exception entry, stop, return from exception, user-mode entry, data write, pulse, taken branch, instruction begin. Emulator entry therefore shows 0xD even when an exception input is also set.
- R9: A request that arrives while a payload is being sent waits in one pending slot. Its marker appears during the last nibble of the running payload, and its first nibble follows in the next cycle.
- R10: A request that finds the pending slot full is discarded without disturbing the pending payload, and `overflow` goes high and stays high until reset.
- R11: After reset, `pst` is 0x0, `ddata` is 0x0 and `overflow` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Trace clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_begin | input | 1 | First cycle of an instruction |
| ev_branch | input | 1 | Taken branch this cycle |
| br_target | input | 32 | Branch target address |
| ev_user | input | 1 | Instruction that entered user mode completed |
| ev_rte | input | 1 | Return-from-exception begins |
| ev_pulse | input | 1 | Pulse (trigger) instruction begins |
| ev_wdata | input | 1 | Data-write instruction begins |
| wsize | input | 2 | Data-write operand size: 0 byte, 1 word, 2/3 longword |
| wdata | input | 32 | Data-write operand |
| ev_exc | input | 1 | Exception processing begins |
| ev_emu | input | 1 | Emulator-mode entry begins |
| ev_stop | input | 1 | Core stops |
| ev_halt | input | 1 | Core halts |
| exc_done | input | 1 | Exception or emulator entry has completed |
| wake | input | 1 | Interrupt that ends stopped mode |
| restart | input | 1 | Restart that ends halted mode |
| cfg_br_bytes | input | 3 | Branch address bytes to send (0 = none, above 4 = 4) |
| pst | output | 4 | Processor status nibble |
| ddata | output | 4 | Payload data nibble |
| overflow | output | 1 | Sticky flag: a payload request was dropped |

## Verification
The bench targets the cycle in which the marker appears. A design that is off by one there puts the marker beside the first nibble, or leaves an idle cycle before it. The bench also targets nibble and byte order: a reversed design sends the high nibble or the top byte first, and a word-size write that sent the whole operand shows stray nibbles. Back-to-back payloads check that the queued marker overlaps the last nibble of the previous payload, and a third request checks that a drop sets the flag without corrupting the queued data. Mode tests present begin, branch and wake inputs during held modes. A design that let them through shows a stray code or a late marker, and one where halt exits on `wake` shows 0x0 too early.

// File: rtl/pst_trace_pkg.sv
// Package: shared status codes and core-mode type for the trace encoder.
// Assumes 4-bit status codes as listed in the block requirements.
package pst_trace_pkg;

    typedef enum logic [3:0] {
        PST_CONT   = 4'h0,
        PST_BEGIN  = 4'h1,
        PST_USER   = 4'h3,
        PST_DWRITE = 4'h4,
        PST_BRANCH = 4'h5,
        PST_RTE    = 4'h7,
        PST_MARK1  = 4'h8,
        PST_MARK2  = 4'h9,
        PST_MARK3  = 4'hA,
        PST_MARK4  = 4'hB,
        PST_EXC    = 4'hC,
        PST_EMU    = 4'hD,
        PST_STOP   = 4'hE,
        PST_HALT   = 4'hF
    } pst_code_e;

    typedef enum logic [2:0] {
        MODE_RUN,
        MODE_EXC,
        MODE_EMU,
        MODE_STOP,
        MODE_HALT
    } core_mode_e;

endpackage

// File: rtl/pst_event_arb.sv
// Module: pst_event_arb
// Picks one event per cycle by fixed priority, produces its status code,
// the mode it enters (if any) and the payload request it carries.
// Assumes: purely combinational; the caller disables it while a mode holds.
module pst_event_arb
    import pst_trace_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CFG_W  = 3,
    parameter int BC_W   = 3
) (
    input  logic              in_run,
    input  logic              ev_begin,
    input  logic              ev_branch,
    input  logic [DATA_W-1:0] br_target,
    input  logic              ev_user,
    input  logic              ev_rte,
    input  logic              ev_pulse,
    input  logic              ev_wdata,
    input  logic [1:0]        wsize,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ev_exc,
    input  logic              ev_emu,
    input  logic              ev_stop,
    input  logic              ev_halt,
    input  logic [CFG_W-1:0]  cfg_br_bytes,
    output logic              ev_valid,
    output logic [3:0]        ev_code,
    output core_mode_e        enter_mode,
    output logic              req_valid,
    output logic [BC_W-1:0]   req_bytes,
    output logic [DATA_W-1:0] req_data
);

    localparam int MAX_BYTES = DATA_W / 8;
    localparam logic [CFG_W-1:0] MAX_CFG  = CFG_W'(MAX_BYTES);
    localparam logic [BC_W-1:0]  MAX_BC   = BC_W'(MAX_BYTES);

    logic [BC_W-1:0] wr_bytes;
    logic [BC_W-1:0] br_bytes;

    // Operand size to byte count for data writes.
    always_comb begin
        case (wsize)
            2'd0:    wr_bytes = BC_W'(1);
            2'd1:    wr_bytes = BC_W'(2);
            default: wr_bytes = MAX_BC;
        endcase
    end

    // Configured branch address byte count, clamped to the data width.
    always_comb begin
        if (cfg_br_bytes > MAX_CFG) br_bytes = MAX_BC;
        else                        br_bytes = BC_W'(cfg_br_bytes);
    end

    // Fixed-priority selection of the single event shown this cycle.
    always_comb begin
        ev_valid   = 1'b0;
        ev_code    = PST_CONT;
        enter_mode = MODE_RUN;
        req_valid  = 1'b0;
        req_bytes  = '0;
        req_data   = '0;
        if (in_run) begin
            if (ev_halt) begin
                ev_valid = 1'b1; ev_code = PST_HALT; enter_mode = MODE_HALT;
            end else if (ev_emu) begin
                ev_valid = 1'b1; ev_code = PST_EMU;  enter_mode = MODE_EMU;
            end else if (ev_exc) begin
                ev_valid = 1'b1; ev_code = PST_EXC;  enter_mode = MODE_EXC;
            end else if (ev_stop) begin
                ev_valid = 1'b1; ev_code = PST_STOP; enter_mode = MODE_STOP;
            end else if (ev_rte) begin
                ev_valid = 1'b1; ev_code = PST_RTE;
            end else if (ev_user) begin
                ev_valid = 1'b1; ev_code = PST_USER;
            end else if (ev_wdata) begin
                ev_valid  = 1'b1; ev_code = PST_DWRITE;
                req_valid = 1'b1;
                req_bytes = wr_bytes;
                req_data  = wdata;
            end else if (ev_pulse) begin
                ev_valid = 1'b1; ev_code = PST_DWRITE;
            end else if (ev_branch) begin
                ev_valid  = 1'b1; ev_code = PST_BRANCH;
                req_valid = (cfg_br_bytes != '0);
                req_bytes = br_bytes;
                req_data  = br_target;
            end else if (ev_begin) begin
                ev_valid = 1'b1; ev_code = PST_BEGIN;
            end
        end
    end

endmodule

// File: rtl/pst_mode_ctl.sv
// Module: pst_mode_ctl
// Tracks the multi-cycle core modes (exception, emulator, stopped, halted),
// reports whether a mode code owns the status port and which code it is.
// Assumes: entries come only from the arbiter while in MODE_RUN.
module pst_mode_ctl
    import pst_trace_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  core_mode_e enter_mode,
    input  logic       exc_done,
    input  logic       wake,
    input  logic       restart,
    output logic       in_run,
    output logic       busy,
    output logic [3:0] busy_code
);

    core_mode_e mode_q;
    logic       leave;

    // Exit condition for the current mode.
    always_comb begin
        case (mode_q)
            MODE_EXC, MODE_EMU: leave = exc_done;
            MODE_STOP:          leave = wake;
            MODE_HALT:          leave = restart;
            default:            leave = 1'b0;
        endcase
    end

    // Code held on the status port while a mode stays active.
    always_comb begin
        case (mode_q)
            MODE_EXC:  busy_code = PST_EXC;
            MODE_EMU:  busy_code = PST_EMU;
            MODE_STOP: busy_code = PST_STOP;
            MODE_HALT: busy_code = PST_HALT;
            default:   busy_code = PST_CONT;
        endcase
    end

    assign in_run = (mode_q == MODE_RUN);
    assign busy   = !in_run && !leave;

    // Mode state register: enter from run, return to run on exit.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= MODE_RUN;
        else if (in_run)  mode_q <= enter_mode;
        else if (leave)   mode_q <= MODE_RUN;
    end

    // R7
    halt_ignores_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_HALT && !restart) |=> (mode_q == MODE_HALT));

endmodule

// File: rtl/pst_payload.sv
// Module: pst_payload
// Holds one pending payload request and serializes the active payload onto
// the data nibble, low nibble of the low byte first. Flags dropped requests.
// Assumes: req_valid and mark_go are never high in the same cycle, and
// DATA_W is a multiple of 8 no larger than 32.
module pst_payload #(
    parameter int DATA_W = 32,
    parameter int BC_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [BC_W-1:0]   req_bytes,
    input  logic [DATA_W-1:0] req_data,
    input  logic              mark_go,
    output logic              can_mark,
    output logic [3:0]        mark_code,
    output logic [3:0]        ddata,
    output logic              overflow
);

    localparam int MAX_BYTES = DATA_W / 8;
    localparam int NIB_W     = $clog2(2 * MAX_BYTES + 1);

    logic              pend_v;
    logic [BC_W-1:0]   pend_bytes;
    logic [DATA_W-1:0] pend_data;
    logic [DATA_W-1:0] sh_q;
    logic [NIB_W-1:0]  left_q;
    logic [3:0]        ddata_q;
    logic              ovf_q;

    // A marker may go when a request waits and at most one nibble remains.
    assign can_mark = pend_v && (left_q <= NIB_W'(1));

    // Marker code for the pending byte count.
    always_comb begin
        case (pend_bytes)
            BC_W'(1): mark_code = 4'h8;
            BC_W'(2): mark_code = 4'h9;
            BC_W'(3): mark_code = 4'hA;
            default:  mark_code = 4'hB;
        endcase
    end

    // Pending slot: fill on request when empty, drain when the marker goes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v     <= 1'b0;
            pend_bytes <= '0;
            pend_data  <= '0;
        end else if (mark_go) begin
            pend_v <= 1'b0;
        end else if (req_valid && !pend_v) begin
            pend_v     <= 1'b1;
            pend_bytes <= req_bytes;
            pend_data  <= req_data;
        end
    end

    // Sticky drop flag for requests that find the slot full.
    always_ff @(posedge clk) begin
        if (!rst_n)                               ovf_q <= 1'b0;
        else if (req_valid && pend_v && !mark_go) ovf_q <= 1'b1;
    end

    // Shift register and nibble counter for the active payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            left_q <= '0;
        end else if (mark_go) begin
            sh_q   <= pend_data;
            left_q <= NIB_W'({pend_bytes, 1'b0});
        end else if (left_q != '0) begin
            sh_q   <= sh_q >> 4;
            left_q <= left_q - NIB_W'(1);
        end
    end

    // Registered data nibble: current low nibble while active, else zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              ddata_q <= 4'h0;
        else if (left_q != '0)   ddata_q <= sh_q[3:0];
        else                     ddata_q <= 4'h0;
    end

    assign ddata    = ddata_q;
    assign overflow = ovf_q;

    // R10
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);

    // R10
    drop_keeps_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && pend_v && !mark_go) |=> ($stable(pend_data) && pend_v));

    // R4
    idle_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ddata_q != 4'h0) |-> $past(left_q != '0));

endmodule

// File: rtl/pst_trace_enc.sv
// Module: pst_trace_enc (top)
// Merges mode codes, event codes and byte-count markers onto the status
// nibble, one registered value per cycle, and drives the data nibble.
// Assumes: events are sampled on the rising edge and appear one cycle later.
module pst_trace_enc
    import pst_trace_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CFG_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_begin,
    input  logic              ev_branch,
    input  logic [DATA_W-1:0] br_target,
    input  logic              ev_user,
    input  logic              ev_rte,
    input  logic              ev_pulse,
    input  logic              ev_wdata,
    input  logic [1:0]        wsize,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ev_exc,
    input  logic              ev_emu,
    input  logic              ev_stop,
    input  logic              ev_halt,
    input  logic              exc_done,
    input  logic              wake,
    input  logic              restart,
    input  logic [CFG_W-1:0]  cfg_br_bytes,
    output logic [3:0]        pst,
    output logic [3:0]        ddata,
    output logic              overflow
);

    localparam int BC_W = $clog2(DATA_W / 8 + 1);

    logic              in_run;
    logic              busy;
    logic [3:0]        busy_code;
    logic              ev_valid;
    logic [3:0]        ev_code;
    core_mode_e        enter_mode;
    logic              req_valid;
    logic [BC_W-1:0]   req_bytes;
    logic [DATA_W-1:0] req_data;
    logic              can_mark;
    logic [3:0]        mark_code;
    logic              mark_go;
    logic [3:0]        pst_d;
    logic [3:0]        pst_q;

    pst_event_arb #(.DATA_W(DATA_W), .CFG_W(CFG_W), .BC_W(BC_W)) u_arb (
        .in_run       (in_run),
        .ev_begin     (ev_begin),
        .ev_branch    (ev_branch),
        .br_target    (br_target),
        .ev_user      (ev_user),
        .ev_rte       (ev_rte),
        .ev_pulse     (ev_pulse),
        .ev_wdata     (ev_wdata),
        .wsize        (wsize),
        .wdata        (wdata),
        .ev_exc       (ev_exc),
        .ev_emu       (ev_emu),
        .ev_stop      (ev_stop),
        .ev_halt      (ev_halt),
        .cfg_br_bytes (cfg_br_bytes),
        .ev_valid     (ev_valid),
        .ev_code      (ev_code),
        .enter_mode   (enter_mode),
        .req_valid    (req_valid),
        .req_bytes    (req_bytes),
        .req_data     (req_data)
    );

    pst_mode_ctl u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .enter_mode (enter_mode),
        .exc_done   (exc_done),
        .wake       (wake),
        .restart    (restart),
        .in_run     (in_run),
        .busy       (busy),
        .busy_code  (busy_code)
    );

    pst_payload #(.DATA_W(DATA_W), .BC_W(BC_W)) u_pay (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_bytes (req_bytes),
        .req_data  (req_data),
        .mark_go   (mark_go),
        .can_mark  (can_mark),
        .mark_code (mark_code),
        .ddata     (ddata),
        .overflow  (overflow)
    );

    // The marker only takes a status slot that no mode or event claims.
    assign mark_go = !busy && !ev_valid && can_mark;

    // Status slot selection: mode hold, then event, then marker, else continue.
    always_comb begin
        if (busy)          pst_d = busy_code;
        else if (ev_valid) pst_d = ev_code;
        else if (mark_go)  pst_d = mark_code;
        else               pst_d = PST_CONT;
    end

    // Registered status nibble.
    always_ff @(posedge clk) begin
        if (!rst_n) pst_q <= PST_CONT;
        else        pst_q <= pst_d;
    end

    assign pst = pst_q;

    // R1
    no_reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pst_q != 4'h2) && (pst_q != 4'h6));

    // R7
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pst_q == PST_HALT && !restart) |=> (pst_q == PST_HALT));

    // R3
    marker_then_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pst_q[3:2] == 2'b10) |=> (pst_q[3:2] != 2'b10));

endmodule

// File: tb/tb_pst_trace_enc.sv
module tb_pst_trace_enc;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ev_begin, ev_branch, ev_user, ev_rte, ev_pulse, ev_wdata;
    logic        ev_exc, ev_emu, ev_stop, ev_halt, exc_done, wake, restart;
    logic [1:0]  wsize;
    logic [31:0] wdata, br_target;
    logic [2:0]  cfg_br_bytes;
    logic [3:0]  pst, ddata;
    logic        overflow;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pst_trace_enc dut (
        .clk(clk), .rst_n(rst_n),
        .ev_begin(ev_begin), .ev_branch(ev_branch), .br_target(br_target),
        .ev_user(ev_user), .ev_rte(ev_rte), .ev_pulse(ev_pulse),
        .ev_wdata(ev_wdata), .wsize(wsize), .wdata(wdata),
        .ev_exc(ev_exc), .ev_emu(ev_emu), .ev_stop(ev_stop), .ev_halt(ev_halt),
        .exc_done(exc_done), .wake(wake), .restart(restart),
        .cfg_br_bytes(cfg_br_bytes),
        .pst(pst), .ddata(ddata), .overflow(overflow)
    );

    task automatic clear_inputs();
        ev_begin = 0; ev_branch = 0; ev_user = 0; ev_rte = 0; ev_pulse = 0;
        ev_wdata = 0; ev_exc = 0; ev_emu = 0; ev_stop = 0; ev_halt = 0;
        exc_done = 0; wake = 0; restart = 0;
    endtask

    // One clock: inputs already set; sample after the next falling edge.
    task automatic step(input logic [3:0] exp_pst, input logic [3:0] exp_dd,
                        input string tag);
        @(negedge clk);
        checks++;
        if (pst !== exp_pst || ddata !== exp_dd) begin
            fails++;
            $display("FAIL %s: pst=%h ddata=%h expected pst=%h ddata=%h",
                     tag, pst, ddata, exp_pst, exp_dd);
        end
    endtask

    task automatic check_ovf(input logic exp, input string tag);
        checks++;
        if (overflow !== exp) begin
            fails++;
            $display("FAIL %s: overflow=%b expected %b", tag, overflow, exp);
        end
    endtask

    task automatic do_reset();
        clear_inputs();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic t_reset();
        do_reset();
        step(4'h0, 4'h0, "R11 reset state");
        check_ovf(1'b0, "R11 reset overflow");
    endtask

    task automatic t_begin();
        ev_begin = 1; step(4'h1, 4'h0, "R2 begin");
        clear_inputs();
        step(4'h0, 4'h0, "R2 continue 1");
        step(4'h0, 4'h0, "R2 continue 2");
    endtask

    task automatic t_codes();
        ev_user = 1; step(4'h3, 4'h0, "R1 user entry");
        clear_inputs(); ev_rte = 1; step(4'h7, 4'h0, "R1 rte");
        clear_inputs(); ev_pulse = 1; step(4'h4, 4'h0, "R1 pulse");
        clear_inputs();
        step(4'h0, 4'h0, "R1 pulse no marker");
        step(4'h0, 4'h0, "R1 pulse no data");
    endtask

    task automatic t_wdata();
        // word: two low bytes CD, AB
        ev_wdata = 1; wsize = 2'd1; wdata = 32'h1234ABCD;
        step(4'h4, 4'h0, "R5 word code");
        clear_inputs();
        step(4'h9, 4'h0, "R3 word marker");
        step(4'h0, 4'hD, "R4 word n0");
        step(4'h0, 4'hC, "R4 word n1");
        step(4'h0, 4'hB, "R4 word n2");
        step(4'h0, 4'hA, "R4 word n3");
        step(4'h0, 4'h0, "R4 word idle");
        // longword
        ev_wdata = 1; wsize = 2'd2; wdata = 32'h87654321;
        step(4'h4, 4'h0, "R5 long code");
        clear_inputs();
        step(4'hB, 4'h0, "R3 long marker");
        for (int i = 1; i <= 8; i++) step(4'h0, 4'(i), "R4 long nibble");
        step(4'h0, 4'h0, "R4 long idle");
        // byte, with instruction begins delaying the marker
        ev_wdata = 1; wsize = 2'd0; wdata = 32'hFFFF00A5;
        step(4'h4, 4'h0, "R5 byte code");
        clear_inputs(); ev_begin = 1;
        step(4'h1, 4'h0, "R5 begin delays marker 1");
        step(4'h1, 4'h0, "R5 begin delays marker 2");
        clear_inputs();
        step(4'h8, 4'h0, "R5 byte marker");
        step(4'h0, 4'h5, "R4 byte low nibble");
        step(4'h0, 4'hA, "R4 byte high nibble");
        step(4'h0, 4'h0, "R4 byte idle");
    endtask

    task automatic t_branch();
        cfg_br_bytes = 3'd3; br_target = 32'h00C0FFEE; ev_branch = 1;
        step(4'h5, 4'h0, "R6 branch code");
        clear_inputs();
        step(4'hA, 4'h0, "R6 three-byte marker");
        step(4'h0, 4'hE, "R6 addr n0");
        step(4'h0, 4'hE, "R6 addr n1");
        step(4'h0, 4'hF, "R6 addr n2");
        step(4'h0, 4'hF, "R6 addr n3");
        step(4'h0, 4'h0, "R6 addr n4");
        step(4'h0, 4'hC, "R6 addr n5");
        step(4'h0, 4'h0, "R6 addr idle");
        cfg_br_bytes = 3'd0; ev_branch = 1;
        step(4'h5, 4'h0, "R6 branch no addr");
        clear_inputs();
        step(4'h0, 4'h0, "R6 no marker");
        step(4'h0, 4'h0, "R6 no data");
        cfg_br_bytes = 3'd7; br_target = 32'h11223344; ev_branch = 1;
        step(4'h5, 4'h0, "R6 clamp code");
        clear_inputs();
        step(4'hB, 4'h0, "R6 clamp marker");
        step(4'h0, 4'h4, "R6 clamp n0"); step(4'h0, 4'h4, "R6 clamp n1");
        step(4'h0, 4'h3, "R6 clamp n2"); step(4'h0, 4'h3, "R6 clamp n3");
        step(4'h0, 4'h2, "R6 clamp n4"); step(4'h0, 4'h2, "R6 clamp n5");
        step(4'h0, 4'h1, "R6 clamp n6"); step(4'h0, 4'h1, "R6 clamp n7");
        step(4'h0, 4'h0, "R6 clamp idle");
    endtask

    task automatic t_modes();
        cfg_br_bytes = 3'd3; br_target = 32'h00ABCDEF;
        ev_exc = 1; step(4'hC, 4'h0, "R7 exc entry");
        clear_inputs(); ev_begin = 1; ev_branch = 1;
        step(4'hC, 4'h0, "R7 exc holds 1");
        step(4'hC, 4'h0, "R7 exc holds 2");
        clear_inputs(); exc_done = 1;
        step(4'h0, 4'h0, "R7 exc exit");
        clear_inputs();
        step(4'h0, 4'h0, "R7 ignored branch sends nothing");
        ev_exc = 1; ev_emu = 1;
        step(4'hD, 4'h0, "R8 emulator over exception");
        clear_inputs();
        step(4'hD, 4'h0, "R7 emu holds");
        exc_done = 1; step(4'h0, 4'h0, "R7 emu exit");
        clear_inputs(); ev_stop = 1;
        step(4'hE, 4'h0, "R7 stop entry");
        clear_inputs(); ev_begin = 1;
        step(4'hE, 4'h0, "R7 stop holds");
        clear_inputs(); wake = 1;
        step(4'h0, 4'h0, "R7 stop exit on wake");
        clear_inputs(); ev_halt = 1; ev_begin = 1; ev_wdata = 1; wsize = 2'd0;
        step(4'hF, 4'h0, "R8 halt wins");
        clear_inputs(); wake = 1;
        step(4'hF, 4'h0, "R7 halt ignores wake");
        clear_inputs(); restart = 1;
        step(4'h0, 4'h0, "R7 halt exit on restart");
        clear_inputs();
        step(4'h0, 4'h0, "R8 dropped write sends no marker");
    endtask

    task automatic t_queue();
        ev_wdata = 1; wsize = 2'd2; wdata = 32'h76543210;
        step(4'h4, 4'h0, "R9 first write");
        clear_inputs();
        step(4'hB, 4'h0, "R9 first marker");
        ev_wdata = 1; wsize = 2'd0; wdata = 32'h0000003C;
        step(4'h4, 4'h0, "R9 queued write n0");
        check_ovf(1'b0, "R10 no overflow with free slot");
        wdata = 32'h000000FF;
        step(4'h4, 4'h1, "R10 third write n1");
        check_ovf(1'b1, "R10 overflow set");
        clear_inputs();
        for (int i = 2; i <= 6; i++) step(4'h0, 4'(i), "R9 first payload");
        step(4'h8, 4'h7, "R9 queued marker on last nibble");
        step(4'h0, 4'hC, "R10 queued low nibble intact");
        step(4'h0, 4'h3, "R10 queued high nibble intact");
        step(4'h0, 4'h0, "R9 idle after queue");
        check_ovf(1'b1, "R10 overflow sticky");
        do_reset();
        step(4'h0, 4'h0, "R11 reset again");
        check_ovf(1'b0, "R11 overflow cleared by reset");
    endtask

    initial begin
        wsize = 0; wdata = 0; br_target = 0; cfg_br_bytes = 0;
        @(negedge clk);
        t_reset();
        t_begin();
        t_codes();
        t_wdata();
        t_branch();
        t_modes();
        t_queue();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule